// File: doc/BRIEF.md
# SDRAM Full-Row Burst Write Sequencer

This block sits on the controller side of an SDRAM interface and writes one complete row in a single full-page burst. A request names a bank, a row, a starting column and a device width (x4, x8 or x16). The sequencer opens the row, waits out the row-to-column delay, then issues one WRITE. After that it streams one word per clock while the column address wraps inside the open row. Because a full-page burst never stops on its own, the block counts the row length for the chosen width and ends the burst explicitly. It then either closes the row once write recovery has elapsed or leaves it open.

Upstream data arrives on a valid/ready handshake that is ready for exactly the burst cycles. A cycle without valid data is still spent on its column: the write mask is raised so that location is left untouched, and the column keeps advancing. Requests are taken only while the sequencer is idle, and a one-cycle done pulse marks the end of the sequence.

Top module: `sdram_fpw_seq`

## Requirements
- R1: After reset the sequencer is idle: NOP on the command pins, bank and address outputs zero, data drive and mask low, busy and done low.
- R2: The cycle after an idle cycle that sees start_i high carries ACTIVE ({ras,cas,we}=011) with the requested bank on ba_o and the row on addr_o.
- R3: WRITE ({ras,cas,we}=100) follows ACTIVE after exactly TRCD_CYC cycles, TRCD_CYC = ceil(TRCD_PS/TCK_PS). Every cycle in between is NOP (111).
- R4: The burst occupies exactly one row: 2048 cycles for mode 0 (x4), 1024 for mode 1 (x8), 512 for modes 2 and 3 (x16). dq_oe_o is high in every burst cycle and in no other cycle. Only the first burst cycle carries WRITE; the others carry NOP.
- R5: In burst cycle i, addr_o carries column (m+i) mod L, where m is the start column with bits at and above log2(L) dropped and L is the row length. Column bits 0..9 go to A0..A9, column bit 10 to A11, and A10 is low. Address bits beyond the mode's column width are low.
- R6: During the burst, wready_o is high and dq_o equals wdata_i. dqm_o is high exactly in burst cycles where wvalid_i is low. Outside the burst, dq_o, dqm_o and wready_o are low.
- R7: BURST TERMINATE ({ras,cas,we}=110) is issued in the cycle right after the last burst cycle.
- R8: Without keep-open, PRECHARGE (010) with A10 low and the request bank on ba_o comes TWR_GAP cycles after the last data cycle, TWR_GAP = max(2, ceil(TWR_PS/TCK_PS)). The cycles between BURST TERMINATE and PRECHARGE are NOP.
- R9: With keep_open_i high at the request, no PRECHARGE is issued and the sequence ends right after BURST TERMINATE.
- R10: done_o is high for one cycle, in the cycle after PRECHARGE (or after BURST TERMINATE with keep-open). busy_o is low in that cycle and high from the ACTIVE cycle up to it.
- R11: start_i is ignored while busy_o is high: no new ACTIVE is issued and the running sequence is unchanged.
- R12: cs_n_o is low in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request strobe, taken when idle |
| bank_i | input | BANK_W | Bank to write |
| row_i | input | ADDR_W | Row to open |
| col_i | input | COL_W | Starting column |
| mode_i | input | 2 | Width: 0 x4, 1 x8, 2/3 x16 |
| keep_open_i | input | 1 | Leave the row open after the burst |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| wdata_i | input | DQ_W | Upstream write data |
| wvalid_i | input | 1 | Upstream data valid |
| wready_o | output | 1 | Data accepted this cycle |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| ba_o | output | BANK_W | Bank address |
| addr_o | output | ADDR_W | Row / column address |
| dq_o | output | DQ_W | Write data to the DQ pins |
| dq_oe_o | output | 1 | DQ output enable |
| dqm_o | output | 1 | Data mask |

## Verification
Directed bursts cover each width mode at the wrap corners: a start at column 0, so the last word is the top column, and a start at the topmost column, so the address wraps right after the WRITE. A start column with bits above the mode's width separates correct masking from a counter that runs past the row. Random requests mix banks, rows, modes and the keep-open option, with upstream valid density from sparse to full, so that the DQM pattern shows each masked column still consuming its slot. A start strobe pulsed mid-burst separates a sequencer that ignores it from one that restarts.

// File: rtl/sdram_fpw_pkg.sv
package sdram_fpw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ACT, ST_RCD, ST_BURST, ST_BST, ST_TWR, ST_PRE
  } state_e;

  // {ras_n, cas_n, we_n}
  typedef enum logic [2:0] {
    CMD_NOP = 3'b111,
    CMD_ACT = 3'b011,
    CMD_WR  = 3'b100,
    CMD_BST = 3'b110,
    CMD_PRE = 3'b010
  } cmd_e;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdram_fpw_timer.sv
module sdram_fpw_timer #(
  parameter int W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (load_i)       cnt_q <= val_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/sdram_fpw_col_ctr.sv
module sdram_fpw_col_ctr #(
  parameter int COL_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [1:0]       mode_i,
  input  logic             step_i,
  output logic [COL_W-1:0] col_o,
  output logic             last_o
);

  localparam logic [COL_W-1:0] FULL = '1;

  logic [COL_W-1:0] mask_d, mask_q, col_q, rem_q;

  // x4 uses every column bit, x8 one fewer, x16 two fewer
  always_comb begin
    unique case (mode_i)
      2'd0:    mask_d = FULL;
      2'd1:    mask_d = FULL >> 1;
      default: mask_d = FULL >> 2;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      col_q  <= '0;
      rem_q  <= '0;
    end else if (load_i) begin
      mask_q <= mask_d;
      col_q  <= start_col_i & mask_d;
      rem_q  <= mask_d;
    end else if (step_i) begin
      col_q  <= (col_q + 1'b1) & mask_q;
      if (rem_q != '0) rem_q <= rem_q - 1'b1;
    end
  end

  assign col_o  = col_q;
  assign last_o = (rem_q == '0);

endmodule

// File: rtl/sdram_fpw_pins.sv
module sdram_fpw_pins
  import sdram_fpw_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int BANK_W = 2,
  parameter int COL_W  = 11
) (
  input  state_e            state_i,
  input  logic              first_i,
  input  logic [ADDR_W-1:0] row_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic [BANK_W-1:0] bank_i,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [BANK_W-1:0] ba_o,
  output logic [ADDR_W-1:0] addr_o
);

  cmd_e              cmd;
  logic [ADDR_W-1:0] col_addr;

  // A10 is reserved for the auto-precharge flag, so the column skips it
  for (genvar i = 0; i < ADDR_W; i++) begin : g_cmap
    if (i < 10) begin : g_lo
      if (i < COL_W) begin : g_use
        assign col_addr[i] = col_i[i];
      end else begin : g_zero
        assign col_addr[i] = 1'b0;
      end
    end else if (i == 10) begin : g_a10
      assign col_addr[i] = 1'b0;
    end else begin : g_hi
      if (i - 1 < COL_W) begin : g_use
        assign col_addr[i] = col_i[i-1];
      end else begin : g_zero
        assign col_addr[i] = 1'b0;
      end
    end
  end

  always_comb begin
    cmd    = CMD_NOP;
    addr_o = '0;
    unique case (state_i)
      ST_ACT: begin
        cmd    = CMD_ACT;
        addr_o = row_i;
      end
      ST_BURST: begin
        cmd    = first_i ? CMD_WR : CMD_NOP;
        addr_o = col_addr;
      end
      ST_BST:  cmd = CMD_BST;
      ST_PRE:  cmd = CMD_PRE;
      default: cmd = CMD_NOP;
    endcase
  end

  assign {ras_n_o, cas_n_o, we_n_o} = cmd;
  assign cs_n_o = 1'b0;
  assign ba_o   = (state_i == ST_IDLE) ? '0 : bank_i;

endmodule

// File: rtl/sdram_fpw_seq.sv
module sdram_fpw_seq
  import sdram_fpw_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int BANK_W  = 2,
  parameter int COL_W   = 11,
  parameter int DQ_W    = 16,
  parameter int TCK_PS  = 7000,
  parameter int TRCD_PS = 15000,
  parameter int TWR_PS  = 15000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [ADDR_W-1:0] row_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic [1:0]        mode_i,
  input  logic              keep_open_i,
  output logic              busy_o,
  output logic              done_o,
  input  logic [DQ_W-1:0]   wdata_i,
  input  logic              wvalid_i,
  output logic              wready_o,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [BANK_W-1:0] ba_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DQ_W-1:0]   dq_o,
  output logic              dq_oe_o,
  output logic              dqm_o
);

  localparam int TRCD_CYC = max2(1, ceil_div(TRCD_PS, TCK_PS));
  localparam int TWR_GAP  = max2(2, ceil_div(TWR_PS, TCK_PS));
  localparam int RCD_LD   = (TRCD_CYC >= 2) ? TRCD_CYC - 2 : 0;
  localparam int TWR_LD   = (TWR_GAP >= 3) ? TWR_GAP - 3 : 0;
  localparam int TMR_W    = $clog2(max2(RCD_LD, TWR_LD) + 2);

  state_e            state_q, state_d;
  logic [BANK_W-1:0] bank_q;
  logic [ADDR_W-1:0] row_q;
  logic              keep_q, first_q, done_q;
  logic              accept, in_burst;
  logic              tmr_load, tmr_zero;
  logic [TMR_W-1:0]  tmr_val;
  logic [COL_W-1:0]  col;
  logic              col_last;

  assign accept   = (state_q == ST_IDLE) && start_i;
  assign in_burst = (state_q == ST_BURST);

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = ST_ACT;
      ST_ACT: begin
        if (TRCD_CYC <= 1) state_d = ST_BURST;
        else begin
          state_d  = ST_RCD;
          tmr_load = 1'b1;
          tmr_val  = TMR_W'(RCD_LD);
        end
      end
      ST_RCD:   if (tmr_zero) state_d = ST_BURST;
      ST_BURST: if (col_last) state_d = ST_BST;
      ST_BST: begin
        if (keep_q)            state_d = ST_IDLE;
        else if (TWR_GAP == 2) state_d = ST_PRE;
        else begin
          state_d  = ST_TWR;
          tmr_load = 1'b1;
          tmr_val  = TMR_W'(TWR_LD);
        end
      end
      ST_TWR:  if (tmr_zero) state_d = ST_PRE;
      ST_PRE:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      bank_q  <= '0;
      row_q   <= '0;
      keep_q  <= 1'b0;
      first_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        bank_q <= bank_i;
        row_q  <= row_i;
        keep_q <= keep_open_i;
      end
      first_q <= (state_d == ST_BURST) && !in_burst;
      done_q  <= (state_q == ST_PRE) || ((state_q == ST_BST) && keep_q);
    end
  end

  sdram_fpw_timer #(.W(TMR_W)) i_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .zero_o (tmr_zero)
  );

  sdram_fpw_col_ctr #(.COL_W(COL_W)) i_col_ctr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (accept),
    .start_col_i (col_i),
    .mode_i      (mode_i),
    .step_i      (in_burst),
    .col_o       (col),
    .last_o      (col_last)
  );

  sdram_fpw_pins #(
    .ADDR_W (ADDR_W),
    .BANK_W (BANK_W),
    .COL_W  (COL_W)
  ) i_pins (
    .state_i (state_q),
    .first_i (first_q),
    .row_i   (row_q),
    .col_i   (col),
    .bank_i  (bank_q),
    .cs_n_o  (cs_n_o),
    .ras_n_o (ras_n_o),
    .cas_n_o (cas_n_o),
    .we_n_o  (we_n_o),
    .ba_o    (ba_o),
    .addr_o  (addr_o)
  );

  // A missing word still spends its column; the mask protects it
  assign wready_o = in_burst;
  assign dq_oe_o  = in_burst;
  assign dq_o     = in_burst ? wdata_i : '0;
  assign dqm_o    = in_burst && !wvalid_i;
  assign busy_o   = (state_q != ST_IDLE);
  assign done_o   = done_q;

endmodule

// File: rtl/sdram_fpw_chk.sv
module sdram_fpw_chk
  import sdram_fpw_pkg::*;
#(
  parameter int TCK_PS  = 7000,
  parameter int TRCD_PS = 15000,
  parameter int TWR_PS  = 15000
) (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic busy_o,
  input logic done_o,
  input logic ras_n_o,
  input logic cas_n_o,
  input logic we_n_o,
  input logic dq_oe_o,
  input logic dqm_o
);

  localparam int TRCD_CYC = max2(1, ceil_div(TRCD_PS, TCK_PS));
  localparam int TWR_GAP  = max2(2, ceil_div(TWR_PS, TCK_PS));
  localparam int AW       = $clog2(TRCD_CYC + 2);
  localparam int DW       = $clog2(TWR_GAP + 2);

  logic [2:0]    cmd;
  logic [AW-1:0] since_act;
  logic [DW-1:0] since_dat;

  assign cmd = {ras_n_o, cas_n_o, we_n_o};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_act <= AW'(TRCD_CYC + 1);
      since_dat <= DW'(TWR_GAP + 1);
    end else begin
      if (cmd == CMD_ACT)                  since_act <= AW'(1);
      else if (since_act < AW'(TRCD_CYC + 1)) since_act <= since_act + 1'b1;
      if (dq_oe_o)                         since_dat <= DW'(1);
      else if (since_dat < DW'(TWR_GAP + 1))  since_dat <= since_dat + 1'b1;
    end
  end

  // R3
  write_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == CMD_WR) |-> (since_act == AW'(TRCD_CYC)));

  // R8
  recovery_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == CMD_PRE) |-> (since_dat == DW'(TWR_GAP)));

  // R11
  act_from_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == CMD_ACT) |-> $past(start_i && !busy_o));

  // R10
  done_after_close_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && ($past(cmd) == CMD_PRE || $past(cmd) == CMD_BST)));

  // R7
  terminate_after_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dq_oe_o) |-> (cmd == CMD_BST));

  // R6
  mask_in_burst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dqm_o |-> dq_oe_o);

endmodule

bind sdram_fpw_seq sdram_fpw_chk #(
  .TCK_PS  (TCK_PS),
  .TRCD_PS (TRCD_PS),
  .TWR_PS  (TWR_PS)
) i_sdram_fpw_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .ras_n_o (ras_n_o),
  .cas_n_o (cas_n_o),
  .we_n_o  (we_n_o),
  .dq_oe_o (dq_oe_o),
  .dqm_o   (dqm_o)
);

// File: tb/test_sdram_fpw_seq.sv
module test_sdram_fpw_seq;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W  = 12;
  localparam int BANK_W  = 2;
  localparam int COL_W   = 11;
  localparam int DQ_W    = 16;
  localparam int TCK_PS  = 7000;
  localparam int TRCD_PS = 15000;
  localparam int TWR_PS  = 15000;
  localparam int T_RCD   = (TRCD_PS + TCK_PS - 1) / TCK_PS;
  localparam int T_WRC   = (TWR_PS + TCK_PS - 1) / TCK_PS;
  localparam int T_GAP   = (T_WRC < 2) ? 2 : T_WRC;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [BANK_W-1:0] bank = '0;
  logic [ADDR_W-1:0] row = '0;
  logic [COL_W-1:0]  col = '0;
  logic [1:0]        mode = '0;
  logic              keep = 1'b0;
  logic              busy, done;
  logic [DQ_W-1:0]   wdata = '0;
  logic              wvalid = 1'b0;
  logic              wready;
  logic              cs_n, ras_n, cas_n, we_n;
  logic [BANK_W-1:0] ba;
  logic [ADDR_W-1:0] addr;
  logic [DQ_W-1:0]   dq;
  logic              dq_oe, dqm;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  ended  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_fpw_seq #(
    .ADDR_W(ADDR_W), .BANK_W(BANK_W), .COL_W(COL_W), .DQ_W(DQ_W),
    .TCK_PS(TCK_PS), .TRCD_PS(TRCD_PS), .TWR_PS(TWR_PS)
  ) i_sdram_fpw_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .bank_i(bank),
    .row_i(row), .col_i(col), .mode_i(mode), .keep_open_i(keep),
    .busy_o(busy), .done_o(done), .wdata_i(wdata), .wvalid_i(wvalid),
    .wready_o(wready), .cs_n_o(cs_n), .ras_n_o(ras_n), .cas_n_o(cas_n),
    .we_n_o(we_n), .ba_o(ba), .addr_o(addr), .dq_o(dq), .dq_oe_o(dq_oe),
    .dqm_o(dqm)
  );

  function automatic int row_len(input logic [1:0] m);
    return (m == 2'd0) ? 2048 : (m == 2'd1) ? 1024 : 512;
  endfunction

  // column bits 0..9 -> A0..A9, bit 10 -> A11, A10 low
  function automatic logic [ADDR_W-1:0] col_to_addr(input int c);
    logic [ADDR_W-1:0] r = '0;
    for (int i = 0; i < 10; i++) r[i] = c[i];
    r[11] = c[10];
    return r;
  endfunction

  // {cs,ras,cas,we, ba, addr, oe, dqm, wready, dq, busy, done}
  function automatic logic [39:0] pack(
    input logic [2:0] cmd, input logic [BANK_W-1:0] b, input logic [ADDR_W-1:0] a,
    input logic oe, input logic m, input logic rdy, input logic [DQ_W-1:0] d,
    input logic bz, input logic dn);
    return {1'b0, 1'b0, cmd, b, a, oe, m, rdy, d, bz, dn};
  endfunction

  task automatic check(input string req, input logic [39:0] act, input logic [39:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [39:0] observed();
    return {1'b0, cs_n, ras_n, cas_n, we_n, ba, addr, dq_oe, dqm, wready, dq, busy, done};
  endfunction

  task automatic run_burst(input logic [BANK_W-1:0] b, input logic [ADDR_W-1:0] r,
                           input logic [COL_W-1:0] c, input logic [1:0] m,
                           input logic k, input int vpct, input bit poke);
    int len  = row_len(m);
    int m0   = int'(c) & (len - 1);
    int last = k ? T_RCD + len + 1 : T_RCD + len - 1 + T_GAP + 1;
    @(negedge clk);
    bank = b; row = r; col = c; mode = m; keep = k; start = 1'b1;
    @(posedge clk);
    for (int cyc = 0; cyc <= last; cyc++) begin
      logic [39:0] e;
      string       req;
      @(negedge clk);
      wvalid = (($urandom % 100) < vpct);
      wdata  = DQ_W'($urandom);
      // R11: strobe start with a different request while busy
      start  = poke && (cyc == 5 || cyc == T_RCD + 7);
      if (start) begin
        bank = ~b; row = ~r; col = ~c; mode = ~m; keep = ~k;
      end
      #1;
      if (cyc == 0) begin
        e = pack(3'b011, b, r, 0, 0, 0, '0, 1, 0); req = "R2 R12";
      end else if (cyc < T_RCD) begin
        e = pack(3'b111, b, '0, 0, 0, 0, '0, 1, 0); req = "R3 R11";
      end else if (cyc < T_RCD + len) begin
        int ci = (m0 + cyc - T_RCD) % len;
        e = pack((cyc == T_RCD) ? 3'b100 : 3'b111, b, col_to_addr(ci), 1, !wvalid, 1,
                 wdata, 1, 0);
        req = "R3 R4 R5 R6 R11";
      end else if (cyc == T_RCD + len) begin
        e = pack(3'b110, b, '0, 0, 0, 0, '0, 1, 0); req = "R7";
      end else if (cyc == last) begin
        e = pack(3'b111, '0, '0, 0, 0, 0, '0, 0, 1); req = k ? "R9 R10" : "R10";
      end else if (!k && cyc == last - 1) begin
        e = pack(3'b010, b, '0, 0, 0, 0, '0, 1, 0); req = "R8";
      end else begin
        e = pack(3'b111, b, '0, 0, 0, 0, '0, 1, 0); req = k ? "R9" : "R8";
      end
      check(req, observed(), e);
    end
    start = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    if (!ended) begin
      ended = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    end
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5a5a));
    repeat (3) @(negedge clk);
    // R1: reset state, with stray data inputs toggling
    wvalid = 1'b1; wdata = 16'hbeef;
    #1 check("R1", observed(), pack(3'b111, '0, '0, 0, 0, 0, '0, 0, 0));
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    #1 check("R1", observed(), pack(3'b111, '0, '0, 0, 0, 0, '0, 0, 0));

    // directed corners
    run_burst(2'd1, 12'h0a5, 11'd0,     2'd2, 1'b0, 100, 1'b0); // x16 from column 0
    run_burst(2'd2, 12'hfff, 11'd1023,  2'd1, 1'b0, 60,  1'b1); // x8 wraps at once, start poked
    run_burst(2'd3, 12'h800, 11'd2047,  2'd0, 1'b1, 80,  1'b0); // x4 top column, keep open
    run_burst(2'd0, 12'h123, 11'h7ff,   2'd2, 1'b1, 30,  1'b0); // R5: high start bits dropped
    run_burst(2'd1, 12'h456, 11'h355,   2'd3, 1'b0, 0,   1'b1); // mode 3, all masked

    for (int n = 0; n < 5; n++) begin
      run_burst(BANK_W'($urandom), ADDR_W'($urandom), COL_W'($urandom),
                2'($urandom), 1'($urandom), 40 + int'($urandom % 61), 1'($urandom));
    end

    @(negedge clk);
    #1 check("R10", observed(), pack(3'b111, '0, '0, 0, 0, 0, '0, 0, 0));

    if (!ended) begin
      ended = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    end
    $finish;
  end

endmodule